// File: doc/BRIEF.md
# Password Change Double-Entry Verifier

This block runs the tail of a change-password transaction on a serial memory. It starts once an upstream stage has accepted the old password and seen the acknowledge poll. The bytes that follow are checked against a fixed layout: two zero lead-in bytes, then the new password, then the same password again. The block keeps the first copy in a small buffer. It compares each byte of the second copy with the buffered byte at the same position and keeps a sticky reject flag. The acknowledge it returns for the last byte tells the host whether the two copies agreed.

A stop condition after exactly the right number of matching bytes starts a store. While the store runs, the block holds a busy interval. When that interval ends, it emits a one-cycle commit strobe with the new value and the password slot chosen when the transaction was armed. Any other ending returns the block to standby without a store: a bad lead-in, a mismatch, too few or too many bytes, or an abandoning start condition. Data acknowledge polls are answered from the busy state. A poll right after the stop therefore answers ACK when the change was rejected and NACK while the store runs.

Top module: `pwchg_verifier`

## Requirements
- R1: After reset, ack_vld, poll_vld, busy and commit_vld are all 0.
- R2: Once armed, the first two bytes are the lead-in. Each must be 00h. A lead-in byte that is 00h gets ack_ok=1 and any other value gets ack_ok=0, and a nonzero lead-in makes the change fail.
- R3: Every accepted byte produces ack_vld=1 one cycle later, with ack_ok=1 meaning ACK. The eight first-copy bytes and the first seven second-copy bytes are all answered with ack_ok=1.
- R4: The eighth byte of the second copy is answered with ack_ok=1 only if the lead-in was zero and all eight second-copy bytes equal the first-copy bytes at the same positions. Otherwise it is answered with ack_ok=0.
- R5: A stop after a fully matching sequence raises busy in the next cycle and holds it for exactly BUSY_CYC cycles. commit_vld is high for one cycle, in the first cycle busy is low. In that cycle commit_pw carries the password, with the first password byte received in bits 7:0 and each later byte in the next 8 bits up. commit_sel carries the tgt_sel value sampled at arm.
- R6: A stop after a mismatched second copy or a bad lead-in returns the block to standby with no busy and no commit.
- R7: A stop after fewer than 16 password bytes leaves the stored value untouched, with no busy and no commit. Any byte after the sixteenth is answered with ack_ok=0 and also makes the change fail.
- R8: A poll_req produces poll_vld one cycle later. poll_ack is 0 if busy was high when the poll was taken and 1 otherwise.
- R9: A start condition before the stop abandons the transaction. Later bytes give no ack_vld until the block is armed again.
- R10: While busy, bytes and arm requests are ignored: there is no ack_vld, and an arm during busy does not open a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Old password accepted; begin a change transaction |
| tgt_sel | input | SEL_W | Password slot to change, sampled at arm |
| byte_vld | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| start_det | input | 1 | Start condition seen on the bus |
| stop_det | input | 1 | Stop condition seen on the bus |
| poll_req | input | 1 | Data acknowledge poll command received |
| ack_vld | output | 1 | ack_ok is valid for the previous byte |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| poll_vld | output | 1 | poll_ack is valid |
| poll_ack | output | 1 | 1 = ACK, 0 = NACK (store in progress) |
| busy | output | 1 | Store interval running |
| commit_vld | output | 1 | One-cycle strobe: write commit_pw to commit_sel |
| commit_sel | output | SEL_W | Slot to be written |
| commit_pw | output | 8*PW_BYTES | New password value |

## Verification
The double-entry check is tried with identical copies, copies that differ only in the last byte, copies that differ in a random early byte, and nonzero lead-in bytes. These patterns separate a comparison that is really byte-for-byte and sticky from one that looks only at the final byte. Byte counts of four, seven, eight and nine in the second copy, together with a start in mid-transaction, show that the busy interval and the commit depend on the exact count. Polls right after the stop and after the commit tell the inverted early answer apart from the normal one.

// File: rtl/pwchg_pkg.sv
package pwchg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_FIRST,
        ST_SECOND,
        ST_DONE,
        ST_BUSY
    } pc_state_e;
endpackage

// File: rtl/pwchg_copy_buf.sv
module pwchg_copy_buf #(
    parameter int PW_BYTES = 8,
    localparam int IDX_W = $clog2(PW_BYTES),
    localparam int PW_W  = 8 * PW_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [PW_W-1:0]  pw_flat
);
    logic [7:0] slot_q [PW_BYTES];

    for (genvar g = 0; g < PW_BYTES; g++) begin : g_slot
        logic [7:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) slot_d = wr_byte;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
        assign pw_flat[8*g +: 8] = slot_q[g];
    end

    assign rd_byte = slot_q[rd_idx];
endmodule

// File: rtl/pwchg_busy_timer.sv
module pwchg_busy_timer #(
    parameter int BUSY_CYC = 2000,
    localparam int TW = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = TW'(BUSY_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == TW'(1));
endmodule

// File: rtl/pwchg_verifier.sv
module pwchg_verifier
    import pwchg_pkg::*;
#(
    parameter int PW_BYTES  = 8,
    parameter int HDR_BYTES = 2,
    parameter int SEL_W     = 2,
    parameter int BUSY_CYC  = 2000,
    localparam int IDX_W = $clog2(PW_BYTES),
    localparam int CNT_W = IDX_W + 1,
    localparam int PW_W  = 8 * PW_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [SEL_W-1:0] tgt_sel,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             poll_req,
    output logic             ack_vld,
    output logic             ack_ok,
    output logic             poll_vld,
    output logic             poll_ack,
    output logic             busy,
    output logic             commit_vld,
    output logic [SEL_W-1:0] commit_sel,
    output logic [PW_W-1:0]  commit_pw
);
    typedef struct packed {
        pc_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             bad;
        logic [SEL_W-1:0] sel;
        logic             ack_vld;
        logic             ack_ok;
        logic             poll_vld;
        logic             poll_ack;
        logic             commit_vld;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic       buf_we;
    logic [7:0] buf_rd;
    logic       tmr_start;
    logic       tmr_busy;
    logic       tmr_done;
    logic       byte_diff;
    logic       last_pw;
    logic       last_hdr;

    pwchg_copy_buf #(.PW_BYTES(PW_BYTES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_idx  (cur_q.cnt[IDX_W-1:0]),
        .wr_byte (byte_data),
        .rd_idx  (cur_q.cnt[IDX_W-1:0]),
        .rd_byte (buf_rd),
        .pw_flat (commit_pw)
    );

    pwchg_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    assign byte_diff = (byte_data != buf_rd);
    assign last_pw   = (cur_q.cnt == CNT_W'(PW_BYTES - 1));
    assign last_hdr  = (cur_q.cnt == CNT_W'(HDR_BYTES - 1));

    always_comb begin
        nxt_d            = cur_q;
        nxt_d.ack_vld    = 1'b0;
        nxt_d.commit_vld = 1'b0;
        nxt_d.poll_vld   = poll_req;
        nxt_d.poll_ack   = !tmr_busy;
        buf_we           = 1'b0;
        tmr_start        = 1'b0;

        case (cur_q.st)
            ST_IDLE: begin
                if (arm) begin
                    nxt_d.st  = ST_HDR;
                    nxt_d.cnt = '0;
                    nxt_d.bad = 1'b0;
                    nxt_d.sel = tgt_sel;
                end
            end
            ST_HDR, ST_FIRST, ST_SECOND, ST_DONE: begin
                if (stop_det) begin
                    if (cur_q.st == ST_DONE && !cur_q.bad) begin
                        nxt_d.st  = ST_BUSY;
                        tmr_start = 1'b1;
                    end else begin
                        nxt_d.st = ST_IDLE;
                    end
                end else if (start_det) begin
                    nxt_d.st = ST_IDLE;
                end else if (byte_vld) begin
                    nxt_d.ack_vld = 1'b1;
                    nxt_d.cnt     = cur_q.cnt + 1'b1;
                    case (cur_q.st)
                        ST_HDR: begin
                            nxt_d.ack_ok = (byte_data == 8'h00);
                            if (byte_data != 8'h00) nxt_d.bad = 1'b1;
                            if (last_hdr) begin
                                nxt_d.st  = ST_FIRST;
                                nxt_d.cnt = '0;
                            end
                        end
                        ST_FIRST: begin
                            buf_we       = 1'b1;
                            nxt_d.ack_ok = 1'b1;
                            if (last_pw) begin
                                nxt_d.st  = ST_SECOND;
                                nxt_d.cnt = '0;
                            end
                        end
                        ST_SECOND: begin
                            nxt_d.bad    = cur_q.bad | byte_diff;
                            nxt_d.ack_ok = 1'b1;
                            if (last_pw) begin
                                nxt_d.ack_ok = !(cur_q.bad | byte_diff);
                                nxt_d.st     = ST_DONE;
                                nxt_d.cnt    = '0;
                            end
                        end
                        default: begin
                            nxt_d.ack_ok = 1'b0;
                            nxt_d.bad    = 1'b1;
                            nxt_d.cnt    = '0;
                        end
                    endcase
                end
            end
            ST_BUSY: begin
                if (tmr_done) begin
                    nxt_d.st         = ST_IDLE;
                    nxt_d.commit_vld = 1'b1;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, cnt: '0, bad: 1'b0, sel: '0, ack_vld: 1'b0,
                       ack_ok: 1'b0, poll_vld: 1'b0, poll_ack: 1'b0,
                       commit_vld: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ack_vld    = cur_q.ack_vld;
    assign ack_ok     = cur_q.ack_ok;
    assign poll_vld   = cur_q.poll_vld;
    assign poll_ack   = cur_q.poll_ack;
    assign busy       = tmr_busy;
    assign commit_vld = cur_q.commit_vld;
    assign commit_sel = cur_q.sel;
endmodule

// File: rtl/pwchg_verifier_chk.sv
module pwchg_verifier_chk #(
    parameter int PW_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stop_det,
    input logic            byte_vld,
    input logic            ack_vld,
    input logic            poll_vld,
    input logic            poll_ack,
    input logic            busy,
    input logic            commit_vld,
    input logic [PW_W-1:0] commit_pw
);
    AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_vld)); // R3

    AST_BUSY_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det)); // R5

    AST_COMMIT_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> ($past(busy) && !busy)); // R5

    AST_PW_HELD_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(commit_pw)); // R5

    AST_POLL_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        poll_vld |-> (poll_ack == !$past(busy))); // R8

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack_vld); // R10
endmodule

bind pwchg_verifier pwchg_verifier_chk #(.PW_W(PW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_det   (stop_det),
    .byte_vld   (byte_vld),
    .ack_vld    (ack_vld),
    .poll_vld   (poll_vld),
    .poll_ack   (poll_ack),
    .busy       (busy),
    .commit_vld (commit_vld),
    .commit_pw  (commit_pw)
);

// File: tb/sim_pwchg_verifier.sv
module sim_pwchg_verifier;
    localparam int PERIOD = 10;
    localparam int BUSY   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [1:0]  tgt_sel = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        start_det = 1'b0;
    logic        stop_det = 1'b0;
    logic        poll_req = 1'b0;
    logic        ack_vld, ack_ok, poll_vld, poll_ack, busy, commit_vld;
    logic [1:0]  commit_sel;
    logic [63:0] commit_pw;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pwchg_verifier #(.PW_BYTES(8), .HDR_BYTES(2), .SEL_W(2), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .tgt_sel(tgt_sel),
        .byte_vld(byte_vld), .byte_data(byte_data), .start_det(start_det),
        .stop_det(stop_det), .poll_req(poll_req), .ack_vld(ack_vld),
        .ack_ok(ack_ok), .poll_vld(poll_vld), .poll_ack(poll_ack), .busy(busy),
        .commit_vld(commit_vld), .commit_sel(commit_sel), .commit_pw(commit_pw)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected outcome of a change: lead-in zero, copies equal, exact count.
    function automatic bit exp_good(input logic [7:0] h0, input logic [7:0] h1,
                                    input logic [63:0] a, input logic [63:0] b,
                                    input int n2);
        return (h0 == 8'h00) && (h1 == 8'h00) && (a == b) && (n2 == 8);
    endfunction

    function automatic bit exp_last_ack(input logic [7:0] h0, input logic [7:0] h1,
                                        input logic [63:0] a, input logic [63:0] b);
        return (h0 == 8'h00) && (h1 == 8'h00) && (a == b);
    endfunction

    task automatic pulse_arm(input logic [1:0] sel);
        @(negedge clk); arm = 1'b1; tgt_sel = sel;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req,
                             input logic exp_vld, input logic exp_ok);
        @(negedge clk); byte_vld = 1'b1; byte_data = b;
        @(negedge clk); byte_vld = 1'b0;
        check({req, " ack_vld"}, 64'(ack_vld), 64'(exp_vld));
        if (exp_vld) check({req, " ack_ok"}, 64'(ack_ok), 64'(exp_ok));
    endtask

    // Stop, immediate poll, then follow the busy interval and the commit.
    task automatic finish_xact(input bit good, input logic [1:0] sel, input logic [63:0] pw);
        int bcnt;
        @(negedge clk); stop_det = 1'b1;
        @(negedge clk); stop_det = 1'b0;
        check("R5/R6/R7 busy after stop", 64'(busy), 64'(good));
        bcnt = busy ? 1 : 0;
        poll_req = 1'b1;
        @(negedge clk); poll_req = 1'b0;
        check("R8 poll_vld", 64'(poll_vld), 64'd1);
        check("R8 early poll answer", 64'(poll_ack), 64'(!good));
        if (busy) bcnt++;
        while (busy && bcnt <= BUSY + 2) begin
            @(negedge clk);
            if (busy) bcnt++;
        end
        if (good) begin
            check("R5 busy length", 64'(bcnt), 64'(BUSY));
            check("R5 commit_vld", 64'(commit_vld), 64'd1);
            check("R5 commit_pw", commit_pw, pw);
            check("R5 commit_sel", 64'(commit_sel), 64'(sel));
            @(negedge clk);
            check("R5 commit one cycle", 64'(commit_vld), 64'd0);
        end else begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                check("R6/R7 no store busy", 64'(busy), 64'd0);
                check("R6/R7 no commit", 64'(commit_vld), 64'd0);
            end
        end
        poll_req = 1'b1;
        @(negedge clk); poll_req = 1'b0;
        check("R8 late poll answer", 64'(poll_ack), 64'd1);
    endtask

    task automatic run_xact(input logic [1:0] sel, input logic [7:0] h0, input logic [7:0] h1,
                            input logic [63:0] a, input logic [63:0] b, input int n2);
        bit g;
        bit la;
        g  = exp_good(h0, h1, a, b, n2);
        la = exp_last_ack(h0, h1, a, b);
        pulse_arm(sel);
        send_byte(h0, "R2 lead-in", 1'b1, h0 == 8'h00);
        send_byte(h1, "R2 lead-in", 1'b1, h1 == 8'h00);
        for (int i = 0; i < 8; i++) send_byte(a[8*i +: 8], "R3 first copy", 1'b1, 1'b1);
        for (int i = 0; i < n2; i++) begin
            if (i < 7)       send_byte(b[8*i +: 8], "R3 second copy", 1'b1, 1'b1);
            else if (i == 7) send_byte(b[8*i +: 8], "R4 last byte", 1'b1, la);
            else             send_byte(b[7:0], "R7 extra byte", 1'b1, 1'b0);
        end
        finish_xact(g, sel, a);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        void'($urandom(32'h5EED_1234));
        #(PERIOD * 3);
        check("R1 ack_vld", 64'(ack_vld), 64'd0);
        check("R1 poll_vld", 64'(poll_vld), 64'd0);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 commit_vld", 64'(commit_vld), 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed: matching copies
        run_xact(2'd1, 8'h00, 8'h00, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 8);
        // Only the last byte differs
        run_xact(2'd2, 8'h00, 8'h00, 64'h1111_2222_3333_4444, 64'h5511_2222_3333_4444, 8);
        // Early byte differs (sticky flag)
        run_xact(2'd0, 8'h00, 8'h00, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAA5, 8);
        // Nonzero lead-in
        run_xact(2'd3, 8'h00, 8'h80, 64'hFEED_FACE_CAFE_BEEF, 64'hFEED_FACE_CAFE_BEEF, 8);
        // Short and long second copies
        run_xact(2'd1, 8'h00, 8'h00, 64'h0F0E_0D0C_0B0A_0908, 64'h0F0E_0D0C_0B0A_0908, 4);
        run_xact(2'd1, 8'h00, 8'h00, 64'h0F0E_0D0C_0B0A_0908, 64'h0F0E_0D0C_0B0A_0908, 7);
        run_xact(2'd2, 8'h00, 8'h00, 64'h7766_5544_3322_1100, 64'h7766_5544_3322_1100, 9);

        // R9: start condition abandons the transaction
        pulse_arm(2'd3);
        send_byte(8'h00, "R9 before start", 1'b1, 1'b1);
        send_byte(8'h00, "R9 before start", 1'b1, 1'b1);
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
        send_byte(8'h42, "R9 after start", 1'b0, 1'b0);
        finish_xact(1'b0, 2'd3, 64'd0);

        // R10: bytes and arm ignored while busy
        a = 64'hC3C3_5A5A_0110_9966;
        pulse_arm(2'd2);
        send_byte(8'h00, "R2 lead-in", 1'b1, 1'b1);
        send_byte(8'h00, "R2 lead-in", 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) send_byte(a[8*i +: 8], "R3 first copy", 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) send_byte(a[8*i +: 8], "R4 second copy", 1'b1, 1'b1);
        @(negedge clk); stop_det = 1'b1;
        @(negedge clk); stop_det = 1'b0;
        check("R10 busy started", 64'(busy), 64'd1);
        send_byte(8'h00, "R10 byte during busy", 1'b0, 1'b0);
        pulse_arm(2'd0);
        while (busy) @(negedge clk);
        check("R10 commit after ignored arm", 64'(commit_vld), 64'd1);
        check("R10 commit_sel kept", 64'(commit_sel), 64'd2);
        send_byte(8'h00, "R10 arm during busy ignored", 1'b0, 1'b0);

        // Random mix
        for (int it = 0; it < 24; it++) begin
            logic [7:0] h0;
            logic [7:0] h1;
            int n2;
            int pick;
            a = {$urandom, $urandom};
            b = a;
            pick = $urandom_range(0, 9);
            if (pick < 3) b[8*$urandom_range(0, 7) +: 8] ^= 8'(1 << $urandom_range(0, 7));
            h0 = (pick == 3) ? 8'($urandom_range(1, 255)) : 8'h00;
            h1 = (pick == 4) ? 8'($urandom_range(1, 255)) : 8'h00;
            n2 = (pick == 5) ? $urandom_range(1, 7) : ((pick == 6) ? 9 : 8);
            run_xact(2'($urandom_range(0, 3)), h0, h1, a, b, n2);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule